// File: doc/BRIEF.md
# Two-Wire Serial Register Access Port

This block is a slave-only two-wire serial control port. An external master uses it to read and write a bank of 8-bit internal registers. A fast system clock oversamples the serial clock (SCL) and serial data (SDA) lines and synchronises them. All protocol decoding then runs synchronously in that clock domain, so no logic is clocked by SCL. The system clock must run at least ten times faster than SCL. Because the port needs only that clock, it stays reachable while the rest of the chip is powered down.

The slave drives SDA only through an open-drain output enable. Every transfer opens with the fixed 7-bit device address and a direction bit. A write transfer then carries a register pointer byte followed by any number of data bytes. A read first sets the pointer with a write-direction transfer. It then issues a repeated start with the read direction, after which the slave returns register contents. The pointer advances after every data byte, so a burst covers consecutive registers and wraps around at 8 bits.

Top module: `sercfg_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start, and a rising SDA while SCL is high is a stop. A start seen at any point, including in the middle of a byte, discards the partial byte and begins a new address phase. A stop releases SDA and returns the port to idle.
- R2: The first byte after a start carries the device address 7'b1000100 in its upper seven bits and the direction in its least significant bit (1 = read, 0 = write). A matching address is acknowledged by pulling SDA low during the ninth SCL pulse.
- R3: On any other address the slave does not acknowledge. It then ignores the bus until the next start: SDA is never pulled low and no register is written.
- R4: In a write transfer the byte after the address is loaded as the register pointer and acknowledged. Every following byte is written to the register at the pointer and acknowledged.
- R5: The pointer increments after each data byte written or read, and it wraps from 0xFF to 0x00.
- R6: After a repeated start with the read direction, the slave drives the register at the pointer, most significant bit first, starting right after its acknowledge clock.
- R7: If the master acknowledges a read byte (SDA low on the ninth pulse), the next register follows. If it does not acknowledge, the slave releases SDA and drives nothing more until the next start.
- R8: The slave changes its SDA drive only after a detected SCL falling edge, so its drive never changes while SCL is high.
- R9: Output `sda_oe` = 1 pulls SDA low and 0 releases the line. After reset the line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The bench sweeps all 128 device addresses.
- Only 7'b1000100 may be acknowledged.
- A wrong match, or a slave that stays engaged after a mismatch, shows up as a stray acknowledge or an overwritten register.

Bursts are checked for the following faults:
- Bursts that cross 0xFF catch a pointer that saturates or fails to advance.
- Long acknowledged read bursts catch an off-by-one bit order or a stale first byte.
- A read ended by a not-acknowledge, followed by extra master clocks, exposes a slave that keeps driving data.
- A start injected in the middle of a byte catches a bit counter that is not cleared and would misread the next address.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_PTR,
    PH_WR,
    PH_RD,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/sercfg_regbank.sv
module sercfg_regbank #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sercfg_fsm.sv
module sercfg_fsm
  import sercfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [PTR_W-1:0]  rd_addr,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  phase_t            phase;
  logic [CNT_W-1:0]  bitcnt;
  logic              ack_slot;
  logic              rnw;
  logic              mack;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txreg;
  logic [PTR_W-1:0]  ptr;

  assign rd_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      bitcnt   <= '0;
      ack_slot <= 1'b0;
      rnw      <= 1'b0;
      mack     <= 1'b1;
      shreg    <= '0;
      txreg    <= '0;
      ptr      <= '0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        phase    <= PH_DEV;
        bitcnt   <= '0;
        ack_slot <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_det) begin
        phase    <= PH_IDLE;
        bitcnt   <= '0;
        ack_slot <= 1'b0;
        sda_oe   <= 1'b0;
      end else begin
        case (phase)
          PH_DEV, PH_PTR, PH_WR: begin
            if (scl_rise && !ack_slot && bitcnt != FULL) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && !ack_slot && bitcnt == FULL) begin
              case (phase)
                PH_DEV: begin
                  if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                    rnw      <= shreg[0];
                    sda_oe   <= 1'b1;
                    ack_slot <= 1'b1;
                  end else begin
                    phase <= PH_SKIP;
                  end
                end
                PH_PTR: begin
                  ptr      <= shreg;
                  sda_oe   <= 1'b1;
                  ack_slot <= 1'b1;
                end
                default: begin
                  wr_en    <= 1'b1;
                  wr_addr  <= ptr;
                  wr_data  <= shreg;
                  ptr      <= ptr + 1'b1;
                  sda_oe   <= 1'b1;
                  ack_slot <= 1'b1;
                end
              endcase
            end else if (scl_fall && ack_slot) begin
              ack_slot <= 1'b0;
              bitcnt   <= '0;
              if (phase == PH_DEV && rnw) begin
                phase  <= PH_RD;
                txreg  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                sda_oe <= 1'b0;
                if (phase == PH_DEV) phase <= PH_PTR;
                else if (phase == PH_PTR) phase <= PH_WR;
              end
            end
          end
          PH_RD: begin
            if (scl_rise) begin
              if (ack_slot) mack <= sda_s;
              else bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (ack_slot) begin
                ack_slot <= 1'b0;
                bitcnt   <= '0;
                if (!mack) begin
                  txreg  <= rd_data;
                  sda_oe <= ~rd_data[BYTE_W-1];
                end else begin
                  sda_oe <= 1'b0;
                  phase  <= PH_SKIP;
                end
              end else if (bitcnt == FULL) begin
                sda_oe   <= 1'b0;
                ack_slot <= 1'b1;
                ptr      <= ptr + 1'b1;
              end else begin
                txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~txreg[BYTE_W-2];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8
  oe_rise_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall));

  // R8
  oe_fall_on_event_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  // R1
  start_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (phase == PH_DEV && bitcnt == '0 && !sda_oe));

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!sda_oe && phase == PH_IDLE));

  // R3
  skip_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP) |-> (!sda_oe && !wr_en));

  // R2
  ack_slot_full_chk: assert property (@(posedge clk) disable iff (rst)
    ack_slot |-> (bitcnt == FULL));
endmodule

// File: rtl/sercfg_slave.sv
module sercfg_slave
  import sercfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1000100,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  sercfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  sercfg_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe)
  );

  sercfg_regbank #(.AW(PTR_W), .DW(BYTE_W)) u_bank (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );
endmodule

// File: tb/sercfg_slave_tb.sv
module sercfg_slave_tb;
  localparam int Q = 4;
  localparam logic [6:0] DEV = 7'b1000100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_bus;
  int   checks = 0;
  int   errors = 0;
  int   oe_viol = 0;
  bit   oe_seen = 1'b0;
  bit   prev_oe = 1'b0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  sercfg_slave u_dut (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (m_scl),
    .sda_i  (sda_bus),
    .sda_oe (sda_oe)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (sda_oe !== prev_oe && m_scl) oe_viol++;
      if (sda_oe) oe_seen = 1'b1;
    end
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(Q);
    m_scl = 1'b1; wt(2*Q);
    m_sda = 1'b0; wt(2*Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b1; wt(2*Q);
    m_sda = 1'b1; wt(2*Q);
  endtask

  task automatic put_bit(input bit b);
    m_sda = b; wt(Q);
    m_scl = 1'b1; wt(2*Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic get_bit(output bit b);
    m_sda = 1'b1; wt(Q);
    m_scl = 1'b1; wt(Q);
    b = sda_bus; wt(Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(!give_ack);
  endtask

  function automatic logic [7:0] pat(input logic [7:0] a, input int seed);
    return 8'((int'(a) * 37) + (seed * 11) + 5);
  endfunction

  task automatic wr_burst(input logic [7:0] start, input int n, input int seed);
    bit ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk(ack, "R2 write address ack", ack, 1);
    send_byte(start, ack);
    chk(ack, "R4 pointer ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(pat(8'(start + i), seed), ack);
      chk(ack, "R4 data ack", ack, 1);
    end
    bus_stop();
  endtask

  task automatic rd_burst(input logic [7:0] start, input int n, input int seed);
    bit ack;
    logic [7:0] v;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk(ack, "R2 address ack before read", ack, 1);
    send_byte(start, ack);
    chk(ack, "R4 pointer ack before read", ack, 1);
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    chk(ack, "R6 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, v);
      chk(v == pat(8'(start + i), seed), "R5 R6 R7 read data", v, pat(8'(start + i), seed));
    end
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] v;
    wt(6);
    rst = 1'b0;
    wt(4);
    // R9 released after reset
    chk(sda_oe == 1'b0, "R9 reset release", sda_oe, 0);

    // R4 R5 R6 R7: burst write then burst read
    wr_burst(8'h20, 32, 1);
    rd_burst(8'h20, 32, 1);

    // R5 pointer wrap on write and read
    wr_burst(8'hFE, 3, 2);
    rd_burst(8'hFF, 2, 2);

    // R2 R3 exhaustive address sweep: only the fixed address answers
    for (int a = 0; a < 128; a++) begin
      if (7'(a) != DEV) begin
        bus_start();
        oe_seen = 1'b0;
        send_byte({7'(a), 1'b0}, ack);
        chk(!ack, "R3 foreign address nack", ack, 0);
        send_byte(8'h30, ack);
        send_byte(8'hAA, ack);
        chk(!oe_seen, "R3 bus ignored after mismatch", oe_seen, 0);
        bus_stop();
      end
    end
    rd_burst(8'h30, 1, 1);

    // R7 not-acknowledge ends the read and the slave stays off the line
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h21, ack);
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    recv_byte(1'b0, v);
    chk(v == pat(8'h21, 1), "R7 single read", v, pat(8'h21, 1));
    oe_seen = 1'b0;
    for (int i = 0; i < 9; i++) begin
      bit b;
      get_bit(b);
    end
    chk(!oe_seen, "R7 released after nack", oe_seen, 0);
    bus_stop();

    // R1 start in the middle of a byte restarts the address phase
    bus_start();
    put_bit(1'b1);
    put_bit(1'b0);
    put_bit(1'b1);
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    chk(ack, "R1 restart address ack", ack, 1);
    send_byte(8'h40, ack);
    send_byte(8'h5C, ack);
    bus_stop();
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h40, ack);
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    recv_byte(1'b0, v);
    bus_stop();
    chk(v == 8'h5C, "R1 write after restart", v, 8'h5C);
    wt(4);
    chk(sda_oe == 1'b0, "R1 idle after stop", sda_oe, 0);

    // R8 drive never changed while SCL high
    chk(oe_viol == 0, "R8 drive changes while SCL high", oe_viol, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule